// File: doc/BRIEF.md
# Reconfiguration Step Sequencer

This block is a central controller for a group of network interface managers. Each manager holds a set of stored configurations. The set is indexed by an operating mode and by a step number. The sequencer broadcasts one mode to all managers and walks them together through a fixed-length sequence of steps. For each step it raises a one-cycle start strobe on every interface. It then waits at a barrier until every interface has reported the step finished. Only then does it move the step index forward and strobe the next step. After the last step the index returns to zero and the sequence repeats.

A host selects the energy/performance operating mode by presenting a value together with a valid strobe. The sequencer never changes the broadcast mode in the middle of a sequence. A request is held pending, and it takes effect when the next sequence begins: either at the wrap from the last step, or when the sequencer leaves idle. While `run` is low the sequencer rests in an idle state and issues no strobes. Each interface signals completion with a one-bit flag. An interface with nothing to transfer in a step sends that flag as well.

Top module: `cfg_step_sequencer`

## Requirements
- R1: A synchronous reset, held high at a rising edge, leaves the block idle from the next cycle: `seq_active` low, `step_go` all zero, `cur_step` 0 and `cfg_mode` 0. The pending mode is also cleared to 0.
- R2: While idle with `run` low, no start strobe is issued. A rising edge that samples `run` high in idle produces the strobe for step 0 in the following cycle, with `seq_active` high.
- R3: A start strobe raises every bit of `step_go` together, and stays high for exactly one cycle.
- R4: After a strobe, the next strobe appears exactly two cycles after the cycle in which the last outstanding interface presents its done flag. It never appears while any interface has not reported since the latest strobe.
- R5: Done flags are sticky. A one-cycle pulse counts, and a flag presented in the strobe cycle itself counts. A flag from an earlier step does not carry into the next step.
- R6: `cur_step` is a binary step number. It increases by one on each barrier release and wraps from SEQ_LEN-1 to 0.
- R7: `cfg_mode` equals the binary value of the most recent host request, and it changes only in the cycle a step-0 strobe opens a sequence. A request made during a sequence is held until then, and a later request replaces an earlier one.
- R8: A request presented in the same cycle as the barrier release of the last step is applied to the sequence that starts right after it.
- R9: If `run` is low when the last step releases, the block returns to idle with `cur_step` 0 and `cfg_mode` unchanged. A later restart applies the pending mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allow sequences to start and to continue past the wrap |
| mode_req_valid | input | 1 | Host mode request strobe |
| mode_req | input | MODE_W | Requested mode, binary |
| iface_done | input | N_IFACE | Per-interface step-complete flags |
| step_go | output | N_IFACE | Per-interface start strobe for the current step |
| cfg_mode | output | MODE_W | Mode broadcast to every interface |
| cur_step | output | STEP_W | Current step number, binary |
| seq_active | output | 1 | High whenever the sequencer is not idle |

## Verification
The barrier is driven from a table of per-interface completion delays. Some entries have every interface finishing in the strobe cycle, some have a single straggler, and some have staggered pulses. Together they separate a correct all-of-N barrier from an any-of-N barrier, from an off-by-one release time, and from a collector that keeps stale flags from the previous step. Mode requests are placed early in a sequence, repeated so that a later one overrides an earlier one, and placed exactly on the wrap cycle. This distinguishes latching at the boundary from latching immediately, and from missing a same-cycle request. Directed cases cover reset in the middle of a run and a return to idle at the wrap followed by a restart.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic adopt_mode;
        logic clr_done;
        logic advance;
    } seq_ctrl_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cfgseq_mode_latch.sv
module cfgseq_mode_latch #(
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              adopt,
    output logic [MODE_W-1:0] active_mode
);
    logic [MODE_W-1:0] pend_q;
    logic [MODE_W-1:0] eff_mode;

    // A request arriving on the boundary cycle wins over the held one.
    assign eff_mode = req_valid ? req_mode : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            active_mode <= '0;
        end else begin
            if (req_valid) pend_q <= req_mode;
            if (adopt) active_mode <= eff_mode;
        end
    end
endmodule

// File: rtl/cfgseq_done_barrier.sv
module cfgseq_done_barrier #(
    parameter int unsigned N_IFACE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [N_IFACE-1:0] done_in,
    output logic               all_done
);
    logic [N_IFACE-1:0] seen_q;

    for (genvar gi = 0; gi < N_IFACE; gi++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)      seen_q[gi] <= 1'b0;
            else if (clr) seen_q[gi] <= done_in[gi];
            else          seen_q[gi] <= seen_q[gi] | done_in[gi];
        end
    end

    assign all_done = &seen_q;
endmodule

// File: rtl/cfgseq_step_counter.sv
module cfgseq_step_counter #(
    parameter int unsigned SEQ_LEN = 4,
    parameter int unsigned STEP_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [STEP_W-1:0] idx,
    output logic              at_last
);
    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(SEQ_LEN - 1);

    assign at_last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst)          idx <= '0;
        else if (advance) idx <= at_last ? '0 : idx + STEP_W'(1);
    end
endmodule

// File: rtl/cfg_step_sequencer.sv
module cfg_step_sequencer
    import cfgseq_pkg::*;
#(
    parameter int unsigned N_IFACE = 4,
    parameter int unsigned N_MODES = 4,
    parameter int unsigned SEQ_LEN = 4,
    localparam int unsigned MODE_W = idx_width(N_MODES),
    localparam int unsigned STEP_W = idx_width(SEQ_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               mode_req_valid,
    input  logic [MODE_W-1:0]  mode_req,
    input  logic [N_IFACE-1:0] iface_done,
    output logic [N_IFACE-1:0] step_go,
    output logic [MODE_W-1:0]  cfg_mode,
    output logic [STEP_W-1:0]  cur_step,
    output logic               seq_active
);
    seq_state_e state_q, state_d;
    seq_ctrl_t  ctl;
    logic       barrier_met;
    logic       last_step;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            SQ_IDLE: begin
                if (run) begin
                    state_d        = SQ_ISSUE;
                    ctl.adopt_mode = 1'b1;
                end
            end
            SQ_ISSUE: begin
                ctl.clr_done = 1'b1;
                state_d      = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (barrier_met) begin
                    ctl.advance = 1'b1;
                    if (!last_step) begin
                        state_d = SQ_ISSUE;
                    end else if (run) begin
                        state_d        = SQ_ISSUE;
                        ctl.adopt_mode = 1'b1;
                    end else begin
                        state_d = SQ_IDLE;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    cfgseq_mode_latch #(.MODE_W(MODE_W)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (mode_req_valid),
        .req_mode   (mode_req),
        .adopt      (ctl.adopt_mode),
        .active_mode(cfg_mode)
    );

    cfgseq_done_barrier #(.N_IFACE(N_IFACE)) u_barrier (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr_done),
        .done_in (iface_done),
        .all_done(barrier_met)
    );

    cfgseq_step_counter #(.SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .advance(ctl.advance),
        .idx    (cur_step),
        .at_last(last_step)
    );

    assign step_go    = {N_IFACE{state_q == SQ_ISSUE}};
    assign seq_active = (state_q != SQ_IDLE);
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
    parameter int unsigned N_IFACE = 4,
    parameter int unsigned MODE_W  = 2,
    parameter int unsigned STEP_W  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [N_IFACE-1:0] iface_done,
    input logic [N_IFACE-1:0] step_go,
    input logic [MODE_W-1:0]  cfg_mode,
    input logic [STEP_W-1:0]  cur_step,
    input logic               seq_active
);
    logic [N_IFACE-1:0] seen_c;

    always_ff @(posedge clk) begin
        if (rst)           seen_c <= '0;
        else if (|step_go) seen_c <= iface_done;
        else               seen_c <= seen_c | iface_done;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (step_go == '0 && cur_step == '0 && !seq_active && cfg_mode == '0));

    assert_go_uniform_R3: assert property (@(posedge clk) disable iff (rst)
        (step_go == '0 || step_go == '1));

    assert_go_single_R3: assert property (@(posedge clk) disable iff (rst)
        (|step_go) |=> !(|step_go));

    assert_barrier_all_R4: assert property (@(posedge clk) disable iff (rst)
        ((|step_go) && !$past(|step_go) && $past(seq_active)) |-> $past(&seen_c));

    assert_step_order_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cur_step != $past(cur_step)) |->
            (cur_step == $past(cur_step) + STEP_W'(1) || cur_step == '0));

    assert_mode_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_mode != $past(cfg_mode)) |->
            ((|step_go) && cur_step == '0));
endmodule

bind cfg_step_sequencer cfgseq_checker #(
    .N_IFACE(N_IFACE),
    .MODE_W (MODE_W),
    .STEP_W (STEP_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .iface_done(iface_done),
    .step_go   (step_go),
    .cfg_mode  (cfg_mode),
    .cur_step  (cur_step),
    .seq_active(seq_active)
);

// File: tb/test_cfg_step_sequencer.sv
module test_cfg_step_sequencer;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       mode_req_valid = 1'b0;
    logic [1:0] mode_req = '0;
    logic [3:0] iface_done = '0;
    logic [3:0] step_go;
    logic [1:0] cfg_mode;
    logic [1:0] cur_step;
    logic       seq_active;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;
    int exp_step = 0;
    int exp_mode = 0;
    int pend_mode = 0;

    always #5 clk = ~clk;

    cfg_step_sequencer i_cfg_step_sequencer (
        .clk(clk), .rst(rst), .run(run),
        .mode_req_valid(mode_req_valid), .mode_req(mode_req),
        .iface_done(iface_done), .step_go(step_go),
        .cfg_mode(cfg_mode), .cur_step(cur_step), .seq_active(seq_active)
    );

    // {req_valid, req_mode[1:0], delay3, delay2, delay1, delay0}
    localparam logic [14:0] VEC [0:7] = '{
        {1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {1'b1, 2'd2, 3'd1, 3'd3, 3'd0, 3'd2},
        {1'b0, 2'd0, 3'd5, 3'd0, 3'd0, 3'd0},
        {1'b0, 2'd0, 3'd2, 3'd2, 3'd2, 3'd2},
        {1'b1, 2'd1, 3'd0, 3'd1, 3'd2, 3'd3},
        {1'b1, 2'd3, 3'd4, 3'd0, 3'd4, 3'd1},
        {1'b0, 2'd0, 3'd0, 3'd0, 3'd6, 3'd0},
        {1'b0, 2'd0, 3'd1, 3'd0, 3'd0, 3'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Called at a negedge where a strobe is visible; returns at the next strobe.
    task automatic run_step(input logic [11:0] dly, input bit rv, input int rm,
                            input int rat, input string tag);
        int dmax = 0;
        bit wrap_idle;
        for (int i = 0; i < N; i++) if (int'(dly[3*i +: 3]) > dmax) dmax = int'(dly[3*i +: 3]);
        check(step_go == 4'hF, "R3", {tag, " strobe all lanes"}, step_go, 15);
        check(cur_step == 2'(exp_step), "R6", {tag, " step index"}, cur_step, exp_step);
        check(cfg_mode == 2'(exp_mode), "R7", {tag, " broadcast mode"}, cfg_mode, exp_mode);
        wrap_idle = (exp_step == 3) && !run;
        for (int c = 0; c <= dmax + 1; c++) begin
            logic [3:0] m = '0;
            for (int i = 0; i < N; i++) m[i] = (int'(dly[3*i +: 3]) == c);
            iface_done     = m;
            mode_req_valid = rv && (c == rat);
            mode_req       = 2'(rm);
            @(negedge clk);
            if (c < dmax + 1)
                check(step_go == 4'h0, "R4", {tag, " no early strobe"}, step_go, 0);
            else
                check(step_go == (wrap_idle ? 4'h0 : 4'hF), "R4",
                      {tag, " strobe at barrier+2"}, step_go, wrap_idle ? 0 : 15);
        end
        iface_done = '0;
        mode_req_valid = 1'b0;
        if (rv) pend_mode = rm;
        exp_step = (exp_step + 1) % 4;
        if (exp_step == 0 && !wrap_idle) exp_mode = pend_mode;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(step_go == 0 && !seq_active, "R1", "reset idle", {seq_active, step_go}, 0);
        check(cur_step == 0 && cfg_mode == 0, "R1", "reset step/mode", {cur_step, cfg_mode}, 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(step_go == 0 && !seq_active, "R2", "idle without run", step_go, 0);
        end
        run = 1'b1;
        @(negedge clk);
        check(seq_active == 1'b1, "R2", "active after run", seq_active, 1);
        check(step_go == 4'hF, "R2", "first strobe one cycle after run", step_go, 15);

        // table walk: two full sequences
        for (int v = 0; v < 8; v++)
            run_step(VEC[v][11:0], VEC[v][14], int'(VEC[v][13:12]), 0, $sformatf("R5 vec%0d", v));

        // straggler after a step where it finished early: stale flag must not count (R5)
        run_step({3'd7, 3'd0, 3'd0, 3'd0}, 1'b0, 0, 0, "R5 stale cleared");
        run_step(12'h0, 1'b0, 0, 0, "R6 step1");
        run_step(12'h0, 1'b0, 0, 0, "R6 step2");
        // R9: drop run before the last step, request lands on the release cycle
        run = 1'b0;
        run_step(12'h0, 1'b1, 1, 1, "R9 wrap to idle");
        repeat (3) begin
            @(negedge clk);
            check(!seq_active && step_go == 0, "R9", "idle after wrap", seq_active, 0);
            check(cur_step == 0 && cfg_mode == 2'd3, "R9", "step 0, mode kept",
                  {cur_step, cfg_mode}, 3);
        end
        run = 1'b1;
        @(negedge clk);
        exp_mode = pend_mode;
        check(cfg_mode == 2'd1, "R9", "restart applies pending", cfg_mode, 1);

        // R8: request in the same cycle as the last-step release
        run_step(12'h0, 1'b0, 0, 0, "R8 step0");
        run_step(12'h0, 1'b0, 0, 0, "R8 step1");
        run_step(12'h0, 1'b0, 0, 0, "R8 step2");
        run_step(12'h0, 1'b1, 2, 1, "R8 step3");
        check(cfg_mode == 2'd2, "R8", "same-cycle request applied", cfg_mode, 2);

        // R1 reset in the middle of a run
        run_step(12'h0, 1'b0, 0, 0, "R1 pre-reset");
        run = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(step_go == 0 && !seq_active, "R1", "mid-run reset idle", {seq_active, step_go}, 0);
        check(cur_step == 0 && cfg_mode == 0, "R1", "mid-run reset step/mode",
              {cur_step, cfg_mode}, 0);
        @(negedge clk);
        check(step_go == 0, "R2", "stays idle after reset", step_go, 0);
        finish_run();
    end
endmodule